// File: doc/BRIEF.md
# Masked Fault and Status Interrupt Aggregator

This block gathers five event sources from a haptic-style driver core (corrupted waveform data, normal completion of a run, supply undervoltage, over-temperature and over-current) and records each one as a sticky flag in a five-bit status word. Whether a raw event is recorded depends on what the core is doing at the time. A running process records everything. A plain standby records nothing. A standby with a bus transaction in flight still records the supply and thermal faults. Completion is recorded only when a run finishes on its own, and never for a streaming run.

A per-bit mask decides which recorded flags may raise the interrupt. The interrupt is a set/reset latch that drives an active-low pin. Any unmasked flag sets the latch. The status-read strobe resets it and also clears every flag. An event that lands in the same cycle as the read survives that read. The analog detectors, the bus slave and the register decoding sit outside this block.

Top module: `fault_irq_aggr`

## Requirements
- R1: Status bit positions are fixed: bit 4 data error, bit 3 completion, bit 2 undervoltage, bit 1 over-temperature, bit 0 over-current. After reset the status word is 0 and `irq_n_o` is 1.
- R2: An over-current pulse is recorded only while `op_state_i` is 2'b01 (running). In 2'b00 (standby), 2'b10 (standby with bus busy) and 2'b11 (treated as standby) it is ignored.
- R3: Undervoltage and over-temperature pulses are recorded in state 2'b01 and in state 2'b10. They are ignored in states 2'b00 and 2'b11.
- R4: A data-error pulse is recorded only in state 2'b01.
- R5: Completion is recorded when `run_end_i` and `run_end_normal_i` are both 1 in state 2'b01 and `stream_run_i` is 0.
- R6: Completion is not recorded when `run_end_normal_i` is 0 (stop trigger), or when an over-current, over-temperature or undervoltage pulse arrives in the same cycle.
- R7: A run flagged as streaming (`stream_run_i`=1) never records completion.
- R8: Flags stay set until a cycle with `stat_rd_i`=1. That read clears all flags, except that an event recorded in the same cycle is still set afterwards.
- R9: A mask bit of 1 blocks its flag from the interrupt but the flag is still recorded. Any set flag whose mask bit is 0 drives `irq_n_o` low.
- R10: Once low, `irq_n_o` stays low until a read. A read returns it high unless an unmasked flag is set in that same cycle.
- R11: Status and interrupt are registered: an event sampled at a clock edge shows on the outputs just after that edge and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_state_i | input | 2 | Core state: 00 standby, 01 running, 10 standby with bus busy, 11 standby |
| stream_run_i | input | 1 | The current run is real-time streaming |
| ev_oc_i | input | 1 | Raw over-current pulse |
| ev_ot_i | input | 1 | Raw over-temperature pulse |
| ev_uv_i | input | 1 | Raw undervoltage pulse |
| ev_data_err_i | input | 1 | Raw corrupted-data pulse |
| run_end_i | input | 1 | Pulse at the end of a run |
| run_end_normal_i | input | 1 | Qualifies `run_end_i`: 1 normal finish, 0 cut short |
| irq_mask_i | input | 5 | Per-flag interrupt mask, 1 blocks |
| stat_rd_i | input | 1 | Status-read strobe |
| status_o | output | 5 | Sticky status flags |
| irq_n_o | output | 1 | Active-low interrupt |

## Verification
The bench targets the state gating corners. Over-current in a bus-busy standby must stay out of the status word, while undervoltage in the same state must get in. A design with a shared gate for all faults would either lose the thermal flags or record stray over-current. A run end that coincides with a fault or a stop trigger, or that ends a streaming run, must leave completion clear. A naive design would report success for an aborted run. The bench also sends a read and a new event in the same cycle, and then unmasks a flag that is already set. A design that lets the read win would drop the event silently. A design that samples the mask only when an event arrives would never interrupt for the flag that was already set.

// File: rtl/fault_irq_pkg.sv
// Shared definitions for the fault and status interrupt aggregator.
// Assumes the five-source bit map below is fixed by software convention.
package fault_irq_pkg;

    localparam int SRC_N  = 5;
    localparam int B_OC   = 0;
    localparam int B_OT   = 1;
    localparam int B_UV   = 2;
    localparam int B_DONE = 3;
    localparam int B_DATA = 4;

    typedef enum logic [1:0] {
        OS_STANDBY  = 2'b00,
        OS_RUN      = 2'b01,
        OS_BUS_BUSY = 2'b10,
        OS_RSVD     = 2'b11
    } op_state_e;

    typedef logic [SRC_N-1:0] src_vec_t;

    // Sources watched in standby while the bus is busy.
    localparam src_vec_t BUSY_WATCH = src_vec_t'((1 << B_UV) | (1 << B_OT));

endpackage

// File: rtl/fault_evt_qualify.sv
// Turns raw event pulses into capture requests, one bit per status flag.
// Gating depends on the core state. Completion needs a normal finish
// that is not a streaming run and does not coincide with a critical fault.
// Assumes that the raw pulses are synchronous to clk.
module fault_evt_qualify
    import fault_irq_pkg::*;
#(
    parameter int W = SRC_N
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [1:0]   op_state_i,
    input  logic         stream_run_i,
    input  logic         ev_oc_i,
    input  logic         ev_ot_i,
    input  logic         ev_uv_i,
    input  logic         ev_data_err_i,
    input  logic         run_end_i,
    input  logic         run_end_normal_i,
    output logic [W-1:0] cap_o
);

    logic         run_now;
    logic         busy_now;
    logic         crit_now;
    logic [W-1:0] raw_vec;

    // Decode the state into the two windows that matter.
    always_comb begin
        run_now  = (op_state_e'(op_state_i) == OS_RUN);
        busy_now = (op_state_e'(op_state_i) == OS_BUS_BUSY);
    end

    // Collect the fault sources into a vector; completion is handled on its own.
    always_comb begin
        raw_vec         = '0;
        raw_vec[B_OC]   = ev_oc_i;
        raw_vec[B_OT]   = ev_ot_i;
        raw_vec[B_UV]   = ev_uv_i;
        raw_vec[B_DATA] = ev_data_err_i;
    end

    // A critical fault during a run aborts that run.
    always_comb crit_now = run_now & (ev_oc_i | ev_ot_i | ev_uv_i);

    for (genvar g = 0; g < W; g++) begin : g_src
        if (g == B_DONE) begin : g_done
            assign cap_o[g] = run_end_i & run_end_normal_i & run_now
                              & ~stream_run_i & ~crit_now;
        end else if (BUSY_WATCH[g]) begin : g_watch
            assign cap_o[g] = raw_vec[g] & (run_now | busy_now);
        end else begin : g_runonly
            assign cap_o[g] = raw_vec[g] & run_now;
        end
    end

    // R6
    done_no_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap_o[B_DONE] |-> !(ev_oc_i || ev_ot_i || ev_uv_i) && run_end_normal_i);

    // R3
    plain_standby_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_state_i == 2'b00 || op_state_i == 2'b11) |-> (cap_o == '0));

endmodule

// File: rtl/fault_stat_reg.sv
// Sticky status flags, one flop per source. A read strobe clears them and a
// capture in the same cycle wins over the clear. Also exports the next value
// so the interrupt latch can see flags as they are written.
module fault_stat_reg #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] cap_i,
    input  logic         rd_i,
    output logic [W-1:0] stat_o,
    output logic [W-1:0] stat_nxt_o
);

    for (genvar g = 0; g < W; g++) begin : g_flag
        // Next value: keep unless read, then OR in any new capture.
        always_comb stat_nxt_o[g] = (stat_o[g] & ~rd_i) | cap_i[g];

        // Hold the flag across cycles.
        always_ff @(posedge clk) begin
            if (!rst_n) stat_o[g] <= 1'b0;
            else        stat_o[g] <= stat_nxt_o[g];
        end
    end

    // R8
    read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && cap_i == '0) |=> (stat_o == '0));

    // R8
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_i |=> ((stat_o & $past(stat_o)) == $past(stat_o)));

endmodule

// File: rtl/fault_irq_latch.sv
// Set/reset interrupt latch with an active-low output. Any unmasked flag in
// the incoming status sets it. A read resets it, but a set in the same cycle wins.
// Assumes mask bit 1 means blocked.
module fault_irq_latch #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] stat_nxt_i,
    input  logic [W-1:0] mask_i,
    input  logic         rd_i,
    output logic         irq_n_o
);

    logic irq_set;
    logic irq_q;

    // Look for any flag the mask lets through.
    always_comb irq_set = |(stat_nxt_i & ~mask_i);

    // Latch update with set priority over reset.
    always_ff @(posedge clk) begin
        if (!rst_n)       irq_q <= 1'b0;
        else if (irq_set) irq_q <= 1'b1;
        else if (rd_i)    irq_q <= 1'b0;
    end

    // Drive the pin active low.
    always_comb irq_n_o = ~irq_q;

    // R10
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_n_o && !rd_i) |=> !irq_n_o);

endmodule

// File: rtl/fault_irq_aggr.sv
// Top of the fault and status interrupt aggregator. It qualifies raw events
// by core state, keeps them as sticky flags and raises a masked active-low
// interrupt that clears on a status read.
module fault_irq_aggr
    import fault_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       op_state_i,
    input  logic             stream_run_i,
    input  logic             ev_oc_i,
    input  logic             ev_ot_i,
    input  logic             ev_uv_i,
    input  logic             ev_data_err_i,
    input  logic             run_end_i,
    input  logic             run_end_normal_i,
    input  logic [SRC_N-1:0] irq_mask_i,
    input  logic             stat_rd_i,
    output logic [SRC_N-1:0] status_o,
    output logic             irq_n_o
);

    src_vec_t cap;
    src_vec_t stat_nxt;

    fault_evt_qualify #(.W(SRC_N)) i_qual (
        .clk              (clk),
        .rst_n            (rst_n),
        .op_state_i       (op_state_i),
        .stream_run_i     (stream_run_i),
        .ev_oc_i          (ev_oc_i),
        .ev_ot_i          (ev_ot_i),
        .ev_uv_i          (ev_uv_i),
        .ev_data_err_i    (ev_data_err_i),
        .run_end_i        (run_end_i),
        .run_end_normal_i (run_end_normal_i),
        .cap_o            (cap)
    );

    fault_stat_reg #(.W(SRC_N)) i_stat (
        .clk        (clk),
        .rst_n      (rst_n),
        .cap_i      (cap),
        .rd_i       (stat_rd_i),
        .stat_o     (status_o),
        .stat_nxt_o (stat_nxt)
    );

    fault_irq_latch #(.W(SRC_N)) i_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .stat_nxt_i (stat_nxt),
        .mask_i     (irq_mask_i),
        .rd_i       (stat_rd_i),
        .irq_n_o    (irq_n_o)
    );

    // R2
    oc_run_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status_o[B_OC]) |-> $past(op_state_i) == 2'b01);

    // R7
    stream_no_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status_o[B_DONE]) |-> !$past(stream_run_i));

    // R9
    unmasked_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        |(status_o & ~$past(irq_mask_i)) |-> !irq_n_o);

endmodule

// File: tb/test_fault_irq_aggr.sv
module test_fault_irq_aggr;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] op_state = 2'b00;
    logic       stream_run = 1'b0;
    logic       ev_oc = 1'b0, ev_ot = 1'b0, ev_uv = 1'b0, ev_de = 1'b0;
    logic       run_end = 1'b0, run_end_ok = 1'b0;
    logic [4:0] mask = 5'h00;
    logic       rd = 1'b0;
    logic [4:0] status;
    logic       irq_n;

    int checks = 0;
    int fails  = 0;
    int exp_stat = 0;
    bit exp_irq  = 1'b0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    fault_irq_aggr i_fault_irq_aggr (
        .clk (clk), .rst_n (rst_n), .op_state_i (op_state),
        .stream_run_i (stream_run), .ev_oc_i (ev_oc), .ev_ot_i (ev_ot),
        .ev_uv_i (ev_uv), .ev_data_err_i (ev_de), .run_end_i (run_end),
        .run_end_normal_i (run_end_ok), .irq_mask_i (mask),
        .stat_rd_i (rd), .status_o (status), .irq_n_o (irq_n)
    );

    // Behavioural reference model, advanced on every rising edge.
    always @(posedge clk) begin
        int cap, nxt;
        bit run, busy, crit;
        if (!rst_n) begin
            exp_stat = 0;
            exp_irq  = 1'b0;
        end else begin
            run  = (op_state == 2'd1);
            busy = (op_state == 2'd2);
            cap = 0;
            if (ev_oc && run)            cap += 1;
            if (ev_ot && (run || busy))  cap += 2;
            if (ev_uv && (run || busy))  cap += 4;
            if (ev_de && run)            cap += 16;
            crit = run && (ev_oc || ev_ot || ev_uv);
            if (run_end && run_end_ok && run && !stream_run && !crit) cap += 8;
            nxt = (rd ? 0 : exp_stat) | cap;
            exp_irq  = ((nxt & ~int'(mask)) != 0) || (exp_irq && !rd);
            exp_stat = nxt;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Per-cycle comparison against the model.
    task automatic cmp_model();
        chk(int'(status) == exp_stat, "R8 model status", int'(status), exp_stat);
        chk(irq_n == !exp_irq, "R10 model irq_n", int'(irq_n), int'(!exp_irq));
    endtask

    task automatic clear_ev();
        ev_oc = 0; ev_ot = 0; ev_uv = 0; ev_de = 0;
        run_end = 0; run_end_ok = 0; rd = 0;
    endtask

    // One clock: inputs already set, advance, sample at the falling edge, then clear pulses.
    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
        cmp_model();
        clear_ev();
    endtask

    task automatic do_read();
        rd = 1;
        cyc();
    endtask

    initial begin
        #(4 * 100000);
        chk(finished, "watchdog expired", 0, 1);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        clear_ev();
        rst_n = 0;
        repeat (2) @(negedge clk);
        // R1 reset state
        chk(status == 5'h00, "R1 reset status", int'(status), 0);
        chk(irq_n == 1'b1, "R1 reset irq_n", int'(irq_n), 1);
        rst_n = 1;
        cyc();

        // R2 R3 R4: plain standby ignores every fault
        op_state = 2'b00;
        ev_oc = 1; ev_ot = 1; ev_uv = 1; ev_de = 1;
        cyc();
        chk(status == 5'h00, "R2 R3 R4 standby ignores", int'(status), 0);
        chk(irq_n == 1'b1, "R3 standby no irq", int'(irq_n), 1);
        op_state = 2'b11;
        ev_ot = 1; ev_uv = 1;
        cyc();
        chk(status == 5'h00, "R3 state 11 ignores", int'(status), 0);

        // R3: bus-busy standby records UV and OT only
        op_state = 2'b10;
        ev_oc = 1; ev_ot = 1; ev_uv = 1; ev_de = 1;
        cyc();
        chk(status == 5'b00110, "R3 busy records uv ot", int'(status), 6);
        chk(irq_n == 1'b0, "R9 unmasked irq low", int'(irq_n), 0);
        do_read();
        chk(status == 5'h00, "R8 read clears", int'(status), 0);
        chk(irq_n == 1'b1, "R10 read releases irq", int'(irq_n), 1);

        // R11 latency and R2 R1 bit map in run
        op_state = 2'b01;
        ev_oc = 1;
        #1;
        chk(status == 5'h00, "R11 no early change", int'(status), 0);
        cyc();
        chk(status == 5'b00001, "R2 R1 oc bit0", int'(status), 1);
        ev_de = 1;
        cyc();
        chk(status == 5'b10001, "R4 R1 data err bit4", int'(status), 17);
        do_read();

        // R5 normal finish
        run_end = 1; run_end_ok = 1;
        cyc();
        chk(status == 5'b01000, "R5 done bit3", int'(status), 8);
        do_read();

        // R6 stop trigger and coincident fault
        run_end = 1; run_end_ok = 0;
        cyc();
        chk(status == 5'h00, "R6 stopped run no done", int'(status), 0);
        run_end = 1; run_end_ok = 1; ev_uv = 1;
        cyc();
        chk(status == 5'b00100, "R6 fault aborts done", int'(status), 4);
        do_read();

        // R7 streaming never completes
        stream_run = 1;
        run_end = 1; run_end_ok = 1;
        cyc();
        chk(status == 5'h00, "R7 streaming no done", int'(status), 0);
        stream_run = 0;

        // R9 masked flag recorded without irq, then unmask
        mask = 5'h1f;
        ev_oc = 1;
        cyc();
        chk(status == 5'b00001, "R9 masked still recorded", int'(status), 1);
        chk(irq_n == 1'b1, "R9 masked no irq", int'(irq_n), 1);
        mask = 5'h1e;
        cyc();
        chk(irq_n == 1'b0, "R9 unmask raises irq", int'(irq_n), 0);

        // R8 R10 sticky hold, then read with coincident event
        repeat (3) cyc();
        chk(status == 5'b00001, "R8 sticky hold", int'(status), 1);
        chk(irq_n == 1'b0, "R10 irq holds", int'(irq_n), 0);
        mask = 5'h00;
        rd = 1; ev_ot = 1;
        cyc();
        chk(status == 5'b00010, "R8 event beats read", int'(status), 2);
        chk(irq_n == 1'b0, "R10 set beats read", int'(irq_n), 0);
        do_read();

        // Random phase against the model
        for (int i = 0; i < 2000; i++) begin
            op_state   = 2'($urandom_range(0, 3));
            stream_run = ($urandom_range(0, 3) == 0);
            ev_oc = ($urandom_range(0, 7) == 0);
            ev_ot = ($urandom_range(0, 7) == 0);
            ev_uv = ($urandom_range(0, 7) == 0);
            ev_de = ($urandom_range(0, 7) == 0);
            run_end    = ($urandom_range(0, 3) == 0);
            run_end_ok = ($urandom_range(0, 3) != 0);
            rd         = ($urandom_range(0, 5) == 0);
            if ($urandom_range(0, 15) == 0) mask = 5'($urandom);
            cyc();
        end

        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule